// File: doc/BRIEF.md
# Read Strobe Eye Centering Engine

This block trains the read strobe delay of one byte lane so that the strobe samples the data bits in the middle of their valid window. On a start pulse it walks the strobe delay code upward from zero. At every code it reseeds a pattern source, issues one read burst, and compares each captured beat against an expected copy built by a second, identical pattern source. Codes where the whole burst matches count as passing. The first contiguous run of passing codes gives the left and right edges. The engine then programs the midpoint as the strobe delay.

Inside the interface the strobe can already sit inside the data window at zero delay. A sweep from zero would then never see the left edge. To prevent this, a programmable data pre-delay is applied first. Whenever the zero code passes, the pre-delay grows by one step and the sweep starts again. The training pattern is either a per-bit toggling sequence or a PRBS7 stream. The PRBS7 stream has long runs of equal bits, which expose intersymbol interference that the toggling sequence hides.

The memory and the delay cells are a behavioural lane model inside the top. The bench sets its skew, eye width and interference margin through ports.

Top module: `eyeTrainTop`

## Requirements
- R1: After reset, busy, done and trainFail are 0, and leftEdge, rightEdge, centreCode, winWidth and strobeDelay are 0.
- R2: The pattern mode is selected by prbsMode.
  - With prbsMode=0, every data bit is 0 on the first beat of a burst and toggles on every later beat.
  - With prbsMode=1, the pattern comes from a 7-bit register s. Each step computes b=s[6]^s[5] and sets s={s[5:0],b}. Each beat takes eight such bits, the first on bit 0.
  - The register is loaded from prbsSeed at the start of every burst. A zero seed is replaced by 1.
- R3: The lane model works in strobe-code space. Let lo=chanSkew+pre-delay and hi=lo+chanWidth-1.
  - A code in [lo,hi] returns clean data.
  - A code in (hi, hi+isiMargin] corrupts, on every beat except the first of the burst, each bit that holds its value from the previous beat.
  - Any other code corrupts every bit.
- R4: A code passes only when all beats of its burst match the expected pattern.
  - If code 0 passes, the pre-delay is incremented and the sweep restarts from code 0.
  - dqPreOut reports the pre-delay in use, starting from dqPreInit.
- R5: leftEdge is the first passing code. rightEdge is the last code of the contiguous pass run that begins there. The sweep stops at the first failing code after that run.
- R6: centreCode = floor((leftEdge+rightEdge)/2) and winWidth = rightEdge-leftEdge+1.
- R7: When done is high, strobeDelay equals centreCode. While busy is high, strobeDelay carries the code under test.
- R8: trainFail is set when winWidth < minWidth.
- R9: If no code passes, trainFail is set and leftEdge, rightEdge, centreCode and winWidth are 0.
- R10: If the run still passes at the top code, the sweep ends there and rightEdge equals the top code.
- R11: If code 0 still passes when the pre-delay is already at its maximum, training ends with trainFail set and all edge results at 0.
- R12: busy is high from the cycle after start until training ends. done is a single-cycle pulse at the end with busy low. start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a training run |
| prbsMode | input | 1 | 0 toggling pattern, 1 PRBS7 |
| prbsSeed | input | 7 | PRBS7 seed (zero replaced by 1) |
| dqPreInit | input | 4 | Initial data pre-delay code |
| minWidth | input | 7 | Smallest acceptable window width |
| chanSkew | input | 7 | Signed lane-model skew, in strobe codes |
| chanWidth | input | 7 | Lane-model clean eye width, in codes |
| isiMargin | input | 3 | Lane-model interference margin, in codes |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle end-of-training pulse |
| trainFail | output | 1 | Training failed |
| leftEdge | output | 6 | First passing strobe code |
| rightEdge | output | 6 | Last passing strobe code of the run |
| centreCode | output | 6 | Programmed centre code |
| winWidth | output | 7 | Passing window width |
| dqPreOut | output | 4 | Data pre-delay in use |
| strobeDelay | output | 6 | Strobe delay driven to the lane |

## Verification
Two things can happen in the same evaluation cycle. The last code can be recorded as the right edge, and the sweep can close with the centre and width computed. Both occur when the window runs past the top code. Directed runs with a skew near the top of the range provoke this, and the bench checks that rightEdge is the top code and that the centre and width include that final code. A second collision is a zero-code pass together with a saturated pre-delay. It is provoked by a large negative skew with a wide eye and judged by the failure flag and zero results.

// File: rtl/eyeTrainPkg.sv
package eyeTrainPkg;

  typedef struct packed {
    logic clearAll;  // new run: clear results
    logic load;      // reseed patterns, clear mismatch
    logic beat;      // one burst beat
    logic record;    // fold pass/fail of current code
    logic finish;    // latch final results
    logic abort;     // pre-delay exhausted
  } eyeCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BURST,
    ST_EVAL,
    ST_DONE
  } eyeState_t;

endpackage

// File: rtl/eyePatGen.sv
module eyePatGen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          step,
  input  logic          prbsMode,
  input  logic [6:0]    seed,
  output logic [DW-1:0] beat
);

  logic [6:0]    lfsr;
  logic [6:0]    lfsrNext;
  logic [DW-1:0] prbsBeat;
  logic          phase;

  always_comb begin
    logic [6:0] s;
    logic       nb;
    s = lfsr;
    prbsBeat = '0;
    for (int i = 0; i < DW; i++) begin
      nb = s[6] ^ s[5];
      prbsBeat[i] = nb;
      s = {s[5:0], nb};
    end
    lfsrNext = s;
  end

  assign beat = prbsMode ? prbsBeat : {DW{phase}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr  <= 7'h01;
      phase <= 1'b0;
    end else if (load) begin
      lfsr  <= (seed == 7'h00) ? 7'h01 : seed;
      phase <= 1'b0;
    end else if (step) begin
      lfsr  <= lfsrNext;
      phase <= ~phase;
    end
  end

  // R2: the generator never reaches the all-zero lock-up state
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 7'h00);

endmodule

// File: rtl/eyeLaneModel.sv
module eyeLaneModel #(
  parameter int DW = 8,
  parameter int CW = 6,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 load,
  input  logic                 step,
  input  logic                 prbsMode,
  input  logic [6:0]           seed,
  input  logic [CW-1:0]        dqsCode,
  input  logic [PW-1:0]        dqPre,
  input  logic signed [CW:0]   skew,
  input  logic [CW:0]          eyeWidth,
  input  logic [IW-1:0]        isiMargin,
  output logic [DW-1:0]        dq
);

  logic [DW-1:0] srcBeat;
  logic [DW-1:0] prevBeat;
  logic [DW-1:0] corrupt;
  logic          firstBeat;

  eyePatGen #(.DW(DW)) uSrc (
    .clk(clk), .rstN(rstN), .load(load), .step(step),
    .prbsMode(prbsMode), .seed(seed), .beat(srcBeat)
  );

  always_comb begin
    int lo, hi, c;
    lo = int'(skew) + int'(dqPre);
    hi = lo + int'(eyeWidth) - 1;
    c  = int'(dqsCode);
    if (c >= lo && c <= hi)
      corrupt = '0;
    else if (c > hi && c <= hi + int'(isiMargin))
      corrupt = firstBeat ? '0 : ~(srcBeat ^ prevBeat);
    else
      corrupt = '1;
  end

  assign dq = srcBeat ^ corrupt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBeat  <= '0;
      firstBeat <= 1'b1;
    end else if (load) begin
      firstBeat <= 1'b1;
    end else if (step) begin
      prevBeat  <= srcBeat;
      firstBeat <= 1'b0;
    end
  end

endmodule

// File: rtl/eyeDatapath.sv
module eyeDatapath
  import eyeTrainPkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  eyeCtl_t       ctl,
  input  logic [CW-1:0] code,
  input  logic [DW-1:0] dq,
  input  logic          prbsMode,
  input  logic [6:0]    seed,
  input  logic [CW:0]   minWidth,
  output logic          passNow,
  output logic          seenLeft,
  output logic [CW-1:0] leftEdge,
  output logic [CW-1:0] rightEdge,
  output logic [CW-1:0] centreCode,
  output logic [CW:0]   winWidth,
  output logic          trainFail
);

  logic [DW-1:0] expBeat;
  logic          mismatch;
  logic [CW-1:0] nextLeft, nextRight;
  logic          nextSeen;
  logic [CW:0]   sumLR, widthCalc;

  eyePatGen #(.DW(DW)) uExp (
    .clk(clk), .rstN(rstN), .load(ctl.load), .step(ctl.beat),
    .prbsMode(prbsMode), .seed(seed), .beat(expBeat)
  );

  assign passNow = !mismatch;

  always_comb begin
    nextLeft  = leftEdge;
    nextRight = rightEdge;
    nextSeen  = seenLeft;
    if (ctl.record && passNow) begin
      nextRight = code;
      if (!seenLeft) begin
        nextLeft = code;
        nextSeen = 1'b1;
      end
    end
    sumLR     = {1'b0, nextLeft} + {1'b0, nextRight};
    widthCalc = nextSeen ? ({1'b0, nextRight} - {1'b0, nextLeft} + 1'b1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mismatch <= 1'b0;
    end else if (ctl.clearAll || ctl.load) begin
      mismatch <= 1'b0;
    end else if (ctl.beat) begin
      mismatch <= mismatch | (dq != expBeat);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      seenLeft   <= 1'b0;
      leftEdge   <= '0;
      rightEdge  <= '0;
      centreCode <= '0;
      winWidth   <= '0;
      trainFail  <= 1'b0;
    end else begin
      seenLeft  <= nextSeen;
      leftEdge  <= nextLeft;
      rightEdge <= nextRight;
      if (ctl.finish) begin
        centreCode <= sumLR[CW:1];
        winWidth   <= widthCalc;
        trainFail  <= ctl.abort || !nextSeen || (widthCalc < minWidth);
      end
    end
  end

  // R5: a recorded run never has its right edge left of its left edge
  a_r5_edges_ordered: assert property (@(posedge clk) disable iff (!rstN)
    seenLeft |-> rightEdge >= leftEdge);

  // R4: code zero is never recorded, it triggers a restart instead
  a_r4_left_not_zero: assert property (@(posedge clk) disable iff (!rstN)
    seenLeft |-> leftEdge != '0);

  // R8: a run reported as good is at least the minimum width
  a_r8_width_meets_min: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.finish) && !trainFail) |-> winWidth >= minWidth);

endmodule

// File: rtl/eyeCtrl.sv
module eyeCtrl
  import eyeTrainPkg::*;
#(
  parameter int CW = 6,
  parameter int PW = 4,
  parameter int BL = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          passNow,
  input  logic          seenLeft,
  input  logic [PW-1:0] dqPreInit,
  output eyeCtl_t       ctl,
  output logic [CW-1:0] code,
  output logic [PW-1:0] dqPre,
  output logic          busy,
  output logic          done
);

  localparam int BCW = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [CW-1:0]  CODE_MAX = {CW{1'b1}};
  localparam logic [PW-1:0]  PRE_MAX  = {PW{1'b1}};
  localparam logic [BCW-1:0] BEAT_LAST = BCW'(BL - 1);

  eyeState_t      state;
  logic [BCW-1:0] beatCnt;
  logic           zeroPass;
  logic           sweepEnd;

  assign zeroPass = passNow && (code == '0);
  assign sweepEnd = (!passNow && seenLeft) || (code == CODE_MAX);
  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign done     = (state == ST_DONE);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE:  ctl.clearAll = start;
      ST_SETUP: ctl.load     = 1'b1;
      ST_BURST: ctl.beat     = 1'b1;
      ST_EVAL: begin
        if (zeroPass) begin
          if (dqPre == PRE_MAX) begin
            ctl.finish = 1'b1;
            ctl.abort  = 1'b1;
          end
        end else begin
          ctl.record = 1'b1;
          ctl.finish = sweepEnd;
        end
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      code    <= '0;
      dqPre   <= '0;
      beatCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          code  <= '0;
          dqPre <= dqPreInit;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          beatCnt <= '0;
          state   <= ST_BURST;
        end
        ST_BURST: begin
          beatCnt <= beatCnt + 1'b1;
          if (beatCnt == BEAT_LAST) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (zeroPass) begin
            if (dqPre == PRE_MAX) state <= ST_DONE;
            else begin
              dqPre <= dqPre + 1'b1;
              state <= ST_SETUP;
            end
          end else if (sweepEnd) begin
            state <= ST_DONE;
          end else begin
            code  <= code + 1'b1;
            state <= ST_SETUP;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: done lasts exactly one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: busy and done never overlap
  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4: the pre-delay only grows during a run
  a_r4_pre_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> dqPre >= $past(dqPre));

endmodule

// File: rtl/eyeTrainTop.sv
module eyeTrainTop
  import eyeTrainPkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6,
  parameter int PW = 4,
  parameter int IW = 3,
  parameter int BL = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 prbsMode,
  input  logic [6:0]           prbsSeed,
  input  logic [PW-1:0]        dqPreInit,
  input  logic [CW:0]          minWidth,
  input  logic signed [CW:0]   chanSkew,
  input  logic [CW:0]          chanWidth,
  input  logic [IW-1:0]        isiMargin,
  output logic                 busy,
  output logic                 done,
  output logic                 trainFail,
  output logic [CW-1:0]        leftEdge,
  output logic [CW-1:0]        rightEdge,
  output logic [CW-1:0]        centreCode,
  output logic [CW:0]          winWidth,
  output logic [PW-1:0]        dqPreOut,
  output logic [CW-1:0]        strobeDelay
);

  eyeCtl_t       ctl;
  logic [CW-1:0] code;
  logic [DW-1:0] dq;
  logic          passNow;
  logic          seenLeft;

  eyeCtrl #(.CW(CW), .PW(PW), .BL(BL)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .passNow(passNow),
    .seenLeft(seenLeft), .dqPreInit(dqPreInit), .ctl(ctl),
    .code(code), .dqPre(dqPreOut), .busy(busy), .done(done)
  );

  eyeLaneModel #(.DW(DW), .CW(CW), .PW(PW), .IW(IW)) uLane (
    .clk(clk), .rstN(rstN), .load(ctl.load), .step(ctl.beat),
    .prbsMode(prbsMode), .seed(prbsSeed), .dqsCode(strobeDelay),
    .dqPre(dqPreOut), .skew(chanSkew), .eyeWidth(chanWidth),
    .isiMargin(isiMargin), .dq(dq)
  );

  eyeDatapath #(.DW(DW), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .code(code), .dq(dq),
    .prbsMode(prbsMode), .seed(prbsSeed), .minWidth(minWidth),
    .passNow(passNow), .seenLeft(seenLeft), .leftEdge(leftEdge),
    .rightEdge(rightEdge), .centreCode(centreCode), .winWidth(winWidth),
    .trainFail(trainFail)
  );

  assign strobeDelay = busy ? code : centreCode;

endmodule

// File: tb/sim_eyeTrainTop.sv
module sim_eyeTrainTop;

  localparam int CLK_PERIOD = 10;
  localparam int CMAX = 63;
  localparam int PMAX = 15;
  localparam int BL   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic prbsMode = 1'b0;
  logic [6:0] prbsSeed = 7'h01;
  logic [3:0] dqPreInit = '0;
  logic [6:0] minWidth = '0;
  logic signed [6:0] chanSkew = '0;
  logic [6:0] chanWidth = 7'd1;
  logic [2:0] isiMargin = '0;
  logic busy, done, trainFail;
  logic [5:0] leftEdge, rightEdge, centreCode, strobeDelay;
  logic [6:0] winWidth;
  logic [3:0] dqPreOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  eyeTrainTop u0 (
    .clk(clk), .rstN(rstN), .start(start), .prbsMode(prbsMode),
    .prbsSeed(prbsSeed), .dqPreInit(dqPreInit), .minWidth(minWidth),
    .chanSkew(chanSkew), .chanWidth(chanWidth), .isiMargin(isiMargin),
    .busy(busy), .done(done), .trainFail(trainFail), .leftEdge(leftEdge),
    .rightEdge(rightEdge), .centreCode(centreCode), .winWidth(winWidth),
    .dqPreOut(dqPreOut), .strobeDelay(strobeDelay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: does the PRBS burst have no bit holding its value between beats
  function automatic bit prbsNoRuns(input logic [6:0] seed);
    logic [6:0] s;
    logic [7:0] cur, prev;
    logic nb;
    s = (seed == 0) ? 7'h01 : seed;
    prev = '0;
    for (int k = 0; k < BL; k++) begin
      for (int i = 0; i < 8; i++) begin
        nb = s[6] ^ s[5];
        cur[i] = nb;
        s = {s[5:0], nb};
      end
      if (k > 0 && (cur ^ prev) != 8'hFF) return 1'b0;
      prev = cur;
    end
    return 1'b1;
  endfunction

  // R3: pass or fail of one code for the lane model
  function automatic bit codePasses(input int c, input int p, input int sk,
                                    input int w, input int isi, input bit prbs,
                                    input bit noRuns);
    int lo, hi;
    lo = sk + p;
    hi = lo + w - 1;
    if (c >= lo && c <= hi) return 1'b1;
    if (c > hi && c <= hi + isi) return prbs ? noRuns : 1'b1;
    return 1'b0;
  endfunction

  task automatic runCase(input int pre, input int sk, input int w, input int isi,
                         input bit prbs, input logic [6:0] seed, input int minW,
                         input string tag);
    int p, l, r, cen, wid, waitN;
    bit abort, found, expFail, nr;
    nr = prbsNoRuns(seed);
    p = pre;
    abort = 0;
    while (codePasses(0, p, sk, w, isi, prbs, nr)) begin
      if (p == PMAX) begin abort = 1; break; end
      p++;
    end
    found = 0; l = 0; r = 0;
    if (!abort) begin
      for (int c = 0; c <= CMAX; c++) begin
        if (codePasses(c, p, sk, w, isi, prbs, nr)) begin
          if (!found) begin found = 1; l = c; end
          r = c;
        end else if (found) break;
      end
    end
    cen = (l + r) / 2;
    wid = found ? r - l + 1 : 0;
    expFail = abort || !found || (wid < minW);

    @(negedge clk);
    dqPreInit = 4'(pre); chanSkew = 7'(sk); chanWidth = 7'(w);
    isiMargin = 3'(isi); prbsMode = prbs; prbsSeed = seed; minWidth = 7'(minW);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R12 busy after start"}, busy, 1);
    waitN = 0;
    while (!done && waitN < 5000) begin @(negedge clk); waitN++; end
    check({tag, " R12 done seen"}, done, 1);
    check({tag, " R12 busy low at done"}, busy, 0);
    check({tag, " R4 pre-delay"}, dqPreOut, p);
    check({tag, " R8/R9/R11 fail flag"}, trainFail, expFail);
    check({tag, " R5 left"}, leftEdge, found ? l : 0);
    check({tag, " R5/R10 right"}, rightEdge, found ? r : 0);
    check({tag, " R6 centre"}, centreCode, found ? cen : 0);
    check({tag, " R6 width"}, winWidth, wid);
    check({tag, " R7 strobe delay"}, strobeDelay, found ? cen : 0);
    @(negedge clk);
    check({tag, " R12 done one cycle"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 fail", trainFail, 0);
    check("R1 centre", centreCode, 0);
    check("R1 width", winWidth, 0);
    check("R1 strobe", strobeDelay, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase(0, 5, 10, 0, 0, 7'h11, 0, "basic");              // R5 R6
    runCase(0, -3, 12, 0, 0, 7'h11, 0, "preBump");           // R4
    runCase(2, -9, 20, 1, 1, 7'h2A, 4, "preBumpPrbs");       // R4 R2
    runCase(0, 55, 20, 0, 0, 7'h05, 0, "topEdge");           // R10
    runCase(0, 50, 13, 2, 0, 7'h05, 0, "topExact");          // R10
    runCase(10, 60, 5, 0, 0, 7'h05, 0, "noEye");             // R9
    runCase(0, 8, 4, 0, 0, 7'h05, 6, "tooNarrow");           // R8
    runCase(0, 8, 6, 0, 0, 7'h05, 6, "exactMin");            // R8
    runCase(0, -40, 60, 0, 0, 7'h05, 0, "preSaturate");      // R11
    runCase(0, 10, 8, 3, 0, 7'h33, 0, "isiToggle");          // R3 R2
    runCase(0, 10, 8, 3, 1, 7'h33, 0, "isiPrbs");            // R3 R2
    runCase(0, 10, 8, 3, 1, 7'h00, 0, "zeroSeed");           // R2
    runCase(0, 1, 1, 0, 0, 7'h05, 0, "oneCode");             // R5 R6

    // R12 start while busy is ignored: results match an undisturbed run
    begin
      @(negedge clk);
      dqPreInit = 0; chanSkew = 7'sd20; chanWidth = 7'd9; isiMargin = 0;
      prbsMode = 0; minWidth = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      check("R12 restart ignored left", leftEdge, 20);
      check("R12 restart ignored right", rightEdge, 28);
      @(negedge clk);
      check("R12 idle after done", busy, 0);
    end

    for (int n = 0; n < 24; n++) begin
      runCase(int'($urandom_range(0, 15)), int'($urandom_range(0, 60)) - 20,
              int'($urandom_range(1, 30)), int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 7'($urandom_range(0, 127)),
              int'($urandom_range(0, 12)), "random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule